// File: doc/BRIEF.md
# SD Card Native-Mode Initialization Sequencer

This block walks a freshly inserted SD card through the native-mode power-up sequence, from idle to the point where its identification register has been read. It does not shift bits onto the card lines. Instead it asks a separate command framer for one command at a time, over a level request and a single-cycle acknowledge. The framer returns the outcome of each command on that acknowledge: timeout, CRC fault, the echoed index field and the response payload.

A pulse on the start input begins a warm-up period. During it the framer keeps the card clock running with CMD held high. Next comes the software reset command. The sequencer then polls the operating-condition query, which is an application command, so every query is preceded by the application-command prefix. Polling continues until the card clears its busy indication. Finally the card identification is requested and captured.

The sequence ends in one of two ways. On success a done flag rises and the identification and ready status are held. On failure an error flag rises with a code that says why.

Top module: `sd_init_seq`

## Requirements
- R1: While reset is applied, and after reset until start: req_o, warm_o, done_o, err_o and card_ready_o are 0, err_code_o is 0 and cid_o is all zero.
- R2: After a start pulse, warm_o is high for exactly INIT_CLKS (default 74) clock cycles with req_o low. Then req_o rises with cmd_idx_o=0, cmd_arg_o=0 and rsp_kind_o=0. The rsp_kind_o encoding is 0 none, 1 short 48-bit, 2 long 136-bit.
- R3: While req_o is high and ack_i is low, req_o, cmd_idx_o, cmd_arg_o and rsp_kind_o stay unchanged. Each ack_i cycle completes exactly the command being requested.
- R4: Once CMD0 is acknowledged, the next request is CMD55 with argument 0 and a short response. Every ACMD41 request directly follows an acknowledged CMD55 that carried no error.
- R5: ACMD41 is requested with argument 0x00100000 and a short response. If rsp_data_i[31] is 0 (busy), the sequencer returns to CMD55. If it is 1, card_ready_o goes to 1 and the next request is CMD2 with argument 0 and a long response.
- R6: A CRC error reported with an ACMD41 response is ignored.
- R7: When CMD2 is acknowledged without error, cid_o takes the 128-bit rsp_data_i, done_o goes to 1 and req_o goes to 0.
- R8: If MAX_POLLS (default 8) ACMD41 responses in a row report busy, the sequencer stops with err_o=1 and err_code_o=3.
- R9: A timeout on a CMD55, ACMD41 or CMD2 response stops the sequence with err_o=1 and err_code_o=1.
- R10: A CRC error on a CMD55 or CMD2 response stops the sequence with err_o=1 and err_code_o=2.
- R11: An echoed index other than 55 for CMD55, or other than 63 for ACMD41, stops the sequence with err_o=1 and err_code_o=4.
- R12: A start pulse received while done or failed clears done_o, err_o, err_code_o, card_ready_o and cid_o on the next cycle and restarts from the warm-up period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the sequence (taken when idle, done or failed) |
| warm_o | output | 1 | Framer should clock the card with CMD held high |
| req_o | output | 1 | Command request to the framer |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| rsp_kind_o | output | 2 | Expected response: 0 none, 1 short, 2 long |
| ack_i | input | 1 | Framer has finished the command; response fields are valid |
| rsp_tmo_i | input | 1 | No response arrived |
| rsp_crc_err_i | input | 1 | Response CRC mismatch |
| rsp_idx_i | input | 6 | Echoed index field of the response |
| rsp_data_i | input | 128 | Response payload: bits 31:0 for short, all bits for long |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Sequence aborted |
| err_code_o | output | 3 | 0 none, 1 timeout, 2 CRC, 3 poll limit, 4 index mismatch |
| card_ready_o | output | 1 | Card has reported ready |
| cid_o | output | 128 | Captured identification register |

## Verification
Most wrong internal states become visible at the command port within one cycle. A wrong successor after an acknowledge shows up at once as a wrong index, argument or response kind on the next request. A lost prefix shows up as an ACMD41 that does not follow a CMD55. An off-by-one in the warm-up or poll counters cannot be seen at once. It appears only at the end of the window, as a warm-up that is one cycle short or long, or as a failure after one poll too many or too few. The bench therefore counts warm-up cycles and runs the poll limit both exactly at its boundary and one poll below it.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WARM, S_CMD0, S_CMD55, S_ACMD41, S_CMD2, S_DONE, S_FAIL
  } state_e;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_TMO = 3'd1, E_CRC = 3'd2, E_POLL = 3'd3, E_IDX = 3'd4
  } err_e;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0, RK_SHORT = 2'd1, RK_LONG = 2'd2
  } rsp_kind_e;

  localparam logic [5:0]  IDX_GO_IDLE  = 6'd0;
  localparam logic [5:0]  IDX_ALL_CID  = 6'd2;
  localparam logic [5:0]  IDX_APP_CMD  = 6'd55;
  localparam logic [5:0]  IDX_OP_COND  = 6'd41;
  localparam logic [5:0]  IDX_NO_ECHO  = 6'd63;
  localparam logic [31:0] ARG_OP_COND  = 32'h0010_0000;
endpackage

// File: rtl/sd_init_warm.sv
module sd_init_warm #(
  parameter int unsigned INIT_CLKS = 74
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(INIT_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/sd_init_poll.sv
module sd_init_poll #(
  parameter int unsigned MAX_POLLS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // this busy reply is the last one allowed
  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/sd_init_rchk.sv
module sd_init_rchk
  import sd_init_pkg::*;
(
  input  state_e     state_i,
  input  logic       tmo_i,
  input  logic       crc_err_i,
  input  logic [5:0] idx_i,
  output err_e       err_o
);
  logic is_op;
  logic idx_bad;

  assign is_op   = (state_i == S_ACMD41);
  assign idx_bad = ((state_i == S_CMD55) && (idx_i != IDX_APP_CMD)) ||
                   (is_op && (idx_i != IDX_NO_ECHO));

  always_comb begin
    if (tmo_i)                  err_o = E_TMO;
    else if (crc_err_i && !is_op) err_o = E_CRC;  // op-cond reply has no valid CRC
    else if (idx_bad)           err_o = E_IDX;
    else                        err_o = E_NONE;
  end
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
  import sd_init_pkg::*;
#(
  parameter int unsigned INIT_CLKS = 74,
  parameter int unsigned MAX_POLLS = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic         warm_o,
  output logic         req_o,
  output logic [5:0]   cmd_idx_o,
  output logic [31:0]  cmd_arg_o,
  output logic [1:0]   rsp_kind_o,
  input  logic         ack_i,
  input  logic         rsp_tmo_i,
  input  logic         rsp_crc_err_i,
  input  logic [5:0]   rsp_idx_i,
  input  logic [127:0] rsp_data_i,
  output logic         done_o,
  output logic         err_o,
  output logic [2:0]   err_code_o,
  output logic         card_ready_o,
  output logic [127:0] cid_o
);
  state_e       state_q;
  err_e         err_q;
  err_e         rsp_err;
  logic         rdy_q;
  logic [127:0] cid_q;
  logic         warm_done;
  logic         poll_last;
  logic         busy_rsp;

  assign busy_rsp = ack_i && (state_q == S_ACMD41) && (rsp_err == E_NONE) && !rsp_data_i[31];

  sd_init_warm #(.INIT_CLKS(INIT_CLKS)) warm_i (
    .clk_i, .rst_ni,
    .en_i   (state_q == S_WARM),
    .done_o (warm_done)
  );

  sd_init_poll #(.MAX_POLLS(MAX_POLLS)) poll_i (
    .clk_i, .rst_ni,
    .clr_i  (state_q == S_WARM),
    .inc_i  (busy_rsp),
    .last_o (poll_last)
  );

  sd_init_rchk rchk_i (
    .state_i   (state_q),
    .tmo_i     (rsp_tmo_i),
    .crc_err_i (rsp_crc_err_i),
    .idx_i     (rsp_idx_i),
    .err_o     (rsp_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      err_q   <= E_NONE;
      rdy_q   <= 1'b0;
      cid_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE, S_DONE, S_FAIL: if (start_i) begin
          state_q <= S_WARM;
          err_q   <= E_NONE;
          rdy_q   <= 1'b0;
          cid_q   <= '0;
        end
        S_WARM: if (warm_done) state_q <= S_CMD0;
        S_CMD0: if (ack_i) state_q <= S_CMD55;
        S_CMD55: if (ack_i) begin
          if (rsp_err != E_NONE) begin
            state_q <= S_FAIL;
            err_q   <= rsp_err;
          end else begin
            state_q <= S_ACMD41;
          end
        end
        S_ACMD41: if (ack_i) begin
          if (rsp_err != E_NONE) begin
            state_q <= S_FAIL;
            err_q   <= rsp_err;
          end else if (rsp_data_i[31]) begin
            rdy_q   <= 1'b1;
            state_q <= S_CMD2;
          end else if (poll_last) begin
            state_q <= S_FAIL;
            err_q   <= E_POLL;
          end else begin
            state_q <= S_CMD55;
          end
        end
        S_CMD2: if (ack_i) begin
          if (rsp_err != E_NONE) begin
            state_q <= S_FAIL;
            err_q   <= rsp_err;
          end else begin
            cid_q   <= rsp_data_i;
            state_q <= S_DONE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_o      = 1'b1;
    cmd_idx_o  = IDX_GO_IDLE;
    cmd_arg_o  = '0;
    rsp_kind_o = RK_NONE;
    case (state_q)
      S_CMD0:   ;
      S_CMD55:  begin cmd_idx_o = IDX_APP_CMD; rsp_kind_o = RK_SHORT; end
      S_ACMD41: begin cmd_idx_o = IDX_OP_COND; cmd_arg_o = ARG_OP_COND; rsp_kind_o = RK_SHORT; end
      S_CMD2:   begin cmd_idx_o = IDX_ALL_CID; rsp_kind_o = RK_LONG; end
      default:  req_o = 1'b0;
    endcase
  end

  assign warm_o       = (state_q == S_WARM);
  assign done_o       = (state_q == S_DONE);
  assign err_o        = (state_q == S_FAIL);
  assign err_code_o   = err_q;
  assign card_ready_o = rdy_q;
  assign cid_o        = cid_q;
endmodule

// File: rtl/sd_init_seq_chk.sv
module sd_init_seq_chk #(
  parameter int unsigned MAX_POLLS = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        warm_o,
  input logic        req_o,
  input logic [5:0]  cmd_idx_o,
  input logic [31:0] cmd_arg_o,
  input logic [1:0]  rsp_kind_o,
  input logic        ack_i,
  input logic        done_o,
  input logic        err_o,
  input logic [2:0]  err_code_o,
  input logic        card_ready_o
);
  logic [15:0] polls_q;
  logic        op_req;
  logic        app_ack_q;

  assign op_req = req_o && (cmd_idx_o == 6'd41);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                polls_q <= '0;
    else if (warm_o)            polls_q <= '0;
    else if (op_req && ack_i)   polls_q <= polls_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) app_ack_q <= 1'b0;
    else         app_ack_q <= req_o && ack_i && (cmd_idx_o == 6'd55);
  end

  // R2
  warm_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_o |-> !req_o);

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(cmd_idx_o) && $stable(cmd_arg_o) && $stable(rsp_kind_o)));

  // R4
  prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req && $rose(op_req)) |-> app_ack_q);

  // R7
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (card_ready_o && !err_o && !req_o));

  // R8
  poll_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    polls_q <= 16'(MAX_POLLS));

  // R9
  err_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o != 3'd0 && !req_o));
endmodule

bind sd_init_seq sd_init_seq_chk #(.MAX_POLLS(MAX_POLLS)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .warm_o       (warm_o),
  .req_o        (req_o),
  .cmd_idx_o    (cmd_idx_o),
  .cmd_arg_o    (cmd_arg_o),
  .rsp_kind_o   (rsp_kind_o),
  .ack_i        (ack_i),
  .done_o       (done_o),
  .err_o        (err_o),
  .err_code_o   (err_code_o),
  .card_ready_o (card_ready_o)
);

// File: tb/sd_init_seq_tb_top.sv
module sd_init_seq_tb_top;
  localparam int INIT_CLKS = 74;
  localparam int MAX_POLLS = 8;
  localparam logic [31:0] OP_ARG = 32'h0010_0000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         warm_o, req_o;
  logic [5:0]   cmd_idx_o;
  logic [31:0]  cmd_arg_o;
  logic [1:0]   rsp_kind_o;
  logic         ack_i = 1'b0;
  logic         rsp_tmo_i = 1'b0;
  logic         rsp_crc_err_i = 1'b0;
  logic [5:0]   rsp_idx_i = '0;
  logic [127:0] rsp_data_i = '0;
  logic         done_o, err_o, card_ready_o;
  logic [2:0]   err_code_o;
  logic [127:0] cid_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  sd_init_seq #(.INIT_CLKS(INIT_CLKS), .MAX_POLLS(MAX_POLLS)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // pulse start and count warm-up cycles
  task automatic kick(output int warm_cnt);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    warm_cnt = 0;
    while (warm_o && warm_cnt < 1000) begin
      if (req_o) chk(0, "R2 req during warm", 1, 0);
      warm_cnt++;
      @(negedge clk_i);
    end
  endtask

  // framer model: wait for request, check it, hold, acknowledge
  task automatic serve(input logic [5:0] e_idx, input logic [31:0] e_arg, input logic [1:0] e_kind,
                       input bit tmo, input bit crc, input logic [5:0] r_idx,
                       input logic [127:0] data, input string tag);
    int n = 0;
    while (!req_o && n < 200) begin n++; @(negedge clk_i); end
    chk(req_o == 1'b1, {tag, " req"}, 128'(req_o), 1);
    chk(cmd_idx_o == e_idx, {tag, " idx"}, 128'(cmd_idx_o), 128'(e_idx));
    chk(cmd_arg_o == e_arg, {tag, " arg"}, 128'(cmd_arg_o), 128'(e_arg));
    chk(rsp_kind_o == e_kind, {tag, " kind"}, 128'(rsp_kind_o), 128'(e_kind));
    repeat (2) @(negedge clk_i);
    chk(req_o && cmd_idx_o == e_idx, "R3 hold", 128'(cmd_idx_o), 128'(e_idx));
    ack_i = 1'b1; rsp_tmo_i = tmo; rsp_crc_err_i = crc; rsp_idx_i = r_idx; rsp_data_i = data;
    @(negedge clk_i);
    ack_i = 1'b0; rsp_tmo_i = 1'b0; rsp_crc_err_i = 1'b0; rsp_idx_i = '0; rsp_data_i = '0;
  endtask

  task automatic pre_poll();
    int w;
    kick(w);
    serve(6'd0, 0, 2'd0, 0, 0, 0, 0, "R2 cmd0");
  endtask

  task automatic app(input string tag);
    serve(6'd55, 0, 2'd1, 0, 0, 6'd55, 128'h120, tag);
  endtask

  task automatic expect_err(input logic [2:0] code, input string tag);
    chk(err_o == 1'b1, {tag, " err"}, 128'(err_o), 1);
    chk(err_code_o == code, {tag, " code"}, 128'(err_code_o), 128'(code));
    chk(!req_o && !done_o, {tag, " idle"}, 128'({req_o, done_o}), 0);
  endtask

  task automatic t_reset();
    chk(!req_o && !warm_o && !done_o && !err_o && !card_ready_o, "R1 flags",
        128'({req_o, warm_o, done_o, err_o, card_ready_o}), 0);
    chk(err_code_o == 0 && cid_o == 0, "R1 regs", cid_o, 0);
  endtask

  task automatic t_nominal();
    int w;
    kick(w);
    chk(w == INIT_CLKS, "R2 warm count", 128'(w), 128'(INIT_CLKS));
    serve(6'd0, 0, 2'd0, 0, 0, 0, 0, "R2 cmd0");
    app("R4 first cmd55");
    serve(6'd41, OP_ARG, 2'd1, 0, 1, 6'd63, 128'h00FF_8000, "R6 busy with crc");
    chk(!err_o && !card_ready_o, "R6 crc ignored", 128'({err_o, card_ready_o}), 0);
    app("R5 repeat cmd55");
    serve(6'd41, OP_ARG, 2'd1, 0, 0, 6'd63, 128'h80FF_8000, "R5 ready");
    chk(card_ready_o == 1'b1, "R5 ready flag", 128'(card_ready_o), 1);
    serve(6'd2, 0, 2'd2, 0, 0, 6'd63, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA, "R7 cmd2");
    chk(done_o && !err_o, "R7 done", 128'({done_o, err_o}), 2);
    chk(cid_o == 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA, "R7 cid", cid_o,
        128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA);
  endtask

  task automatic t_poll_limit();
    pre_poll();
    for (int i = 0; i < MAX_POLLS; i++) begin
      app("R8 cmd55");
      serve(6'd41, OP_ARG, 2'd1, 0, 0, 6'd63, 128'h00FF_8000, "R8 busy");
    end
    expect_err(3'd3, "R8 limit");
  endtask

  task automatic t_poll_edge();
    pre_poll();
    for (int i = 0; i < MAX_POLLS - 1; i++) begin
      app("R8 cmd55");
      serve(6'd41, OP_ARG, 2'd1, 0, 0, 6'd63, 128'h00FF_8000, "R8 busy below limit");
    end
    chk(!err_o, "R8 below limit", 128'(err_o), 0);
    app("R8 cmd55 last");
    serve(6'd41, OP_ARG, 2'd1, 0, 0, 6'd63, 128'h80FF_8000, "R8 ready at limit");
    chk(card_ready_o && !err_o, "R8 ready at limit", 128'({card_ready_o, err_o}), 2);
    serve(6'd2, 0, 2'd2, 0, 0, 6'd63, 128'h1, "R7 cmd2 after edge");
  endtask

  task automatic t_restart();
    int w;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!err_o && !done_o && !card_ready_o && err_code_o == 0 && cid_o == 0, "R12 cleared",
        128'({err_o, done_o, card_ready_o, err_code_o}), 0);
    chk(warm_o == 1'b1, "R12 warm again", 128'(warm_o), 1);
    w = 0;
    while (warm_o && w < 1000) begin w++; @(negedge clk_i); end
    serve(6'd0, 0, 2'd0, 0, 0, 0, 0, "R12 cmd0");
    app("R12 cmd55");
    serve(6'd41, OP_ARG, 2'd1, 1, 0, 6'd63, 0, "R9 op timeout");
    expect_err(3'd1, "R9 timeout");
  endtask

  task automatic t_app_timeout();
    pre_poll();
    serve(6'd55, 0, 2'd1, 1, 0, 6'd0, 0, "R9 cmd55 timeout");
    expect_err(3'd1, "R9 cmd55");
  endtask

  task automatic t_cid_crc();
    pre_poll();
    app("R10 cmd55");
    serve(6'd41, OP_ARG, 2'd1, 0, 0, 6'd63, 128'h80FF_8000, "R10 ready");
    serve(6'd2, 0, 2'd2, 0, 1, 6'd63, 128'h5, "R10 cmd2 crc");
    expect_err(3'd2, "R10 cmd2");
    chk(cid_o == 0, "R10 cid not taken", cid_o, 0);
  endtask

  task automatic t_app_crc();
    pre_poll();
    serve(6'd55, 0, 2'd1, 0, 1, 6'd55, 0, "R10 cmd55 crc");
    expect_err(3'd2, "R10 cmd55");
  endtask

  task automatic t_idx_bad();
    pre_poll();
    app("R11 cmd55");
    serve(6'd41, OP_ARG, 2'd1, 0, 0, 6'd55, 128'h80FF_8000, "R11 op idx");
    expect_err(3'd4, "R11 op idx");
    chk(!card_ready_o, "R11 not ready", 128'(card_ready_o), 0);
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    while (warm_o) @(negedge clk_i);
    serve(6'd0, 0, 2'd0, 0, 0, 0, 0, "R11 cmd0");
    serve(6'd55, 0, 2'd1, 0, 0, 6'd41, 0, "R11 cmd55 idx");
    expect_err(3'd4, "R11 cmd55 idx");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_nominal();
    t_poll_limit();
    t_restart();
    t_poll_edge();
    t_app_timeout();
    t_cid_crc();
    t_app_crc();
    t_idx_bad();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end
endmodule